// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns a group of asynchronous external pins into interrupt requests for a downstream priority controller. Each pin first passes through a two-stage synchroniser. It is then checked against a trigger condition chosen for that pin. The condition is either an edge or a level, in either direction. When the condition holds and the pin is enabled, a sticky per-pin flag is set. The flags drive one request line per pin and one combined request line.

Software sees four registers on a simple byte-wide special-function-register bus: an enable mask, a mode mask, a polarity mask and the flag register. The four sit at consecutive addresses from a base address given as a parameter. A flag is cleared by writing 0 to its bit. Writing 1 to a flag bit leaves it unchanged, so a handler can clear exactly the flags it has serviced.

A pin held in level mode keeps setting its flag for as long as the level stays active, even right after a clear. When a hardware set and a software clear of the same flag fall in one cycle, the set wins.

Top module: `eid_top`

## Requirements
- R1: A flag bit is set only when its pin's enable bit (register at offset 0) is 1 and the pin meets its configured trigger condition. With the enable bit at 0, no condition or transition sets the flag.
- R2: Mode bit (offset 1) = 1 selects edge detection and 0 selects level detection. Polarity bit (offset 2) = 1 selects a rising edge or high level, and 0 selects a falling edge or low level. In edge mode only a transition in the selected direction sets the flag.
- R3: A write to the flag register (offset 3) clears every flag whose written bit is 0 and leaves unchanged every flag whose written bit is 1.
- R4: In edge mode a single transition sets the flag once. After a software clear the flag stays 0 while the pin holds its new level.
- R5: In level mode the flag is set again on every cycle the active level persists, so a clear has no lasting effect until the pin leaves the active level. Once the level is inactive, a clear leaves the flag at 0.
- R6: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends at 1.
- R7: After reset all four registers read 0x00, and all request outputs are 0.
- R8: A pin change driven between clock edges shows up in the flag after the third rising clock edge and not after the second (two synchroniser stages plus the flag register).
- R9: Registers are addressed as BASE+0 enable, BASE+1 mode, BASE+2 polarity, BASE+3 flag, and read back what was written. Other addresses read 0x00, and writes to them change no register.
- R10: irq_o bit i equals flag bit i, and irq_any_o is the OR of all flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external pin levels |
| sfr_addr_i | input | ADDR_W | Register bus address |
| sfr_wr_i | input | 1 | Register write strobe, one cycle per write |
| sfr_wdata_i | input | NUM_PINS | Register write data |
| sfr_rdata_o | output | NUM_PINS | Register read data, combinational from the address |
| irq_o | output | NUM_PINS | Per-pin interrupt request (flag state) |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The assertions assume that the write strobe is a clean single-cycle pulse with a stable address and data. They also assume that mode and polarity bits are not rewritten in the same cycles in which edge pulses are judged. The bench keeps to this by changing configuration only while the pin under test is static, and with its enable bit cleared. The bench sweeps every pin through all four trigger kinds, both enable values and every start/end level pair. It drives pins only on falling clock edges, so each synchroniser sees a clean, predictable transition.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_MODE   = 2'd1,
        REG_POL    = 2'd2,
        REG_FLAG   = 2'd3
    } reg_sel_e;

    localparam int unsigned NUM_REGS = 4;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/eid_detect.sv
module eid_detect #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [NUM_PINS-1:0] mode_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic [NUM_PINS-1:0] hit_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [NUM_PINS-1:0] cond;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < int'(NUM_PINS); i++) begin : g_pin
        logic rise, fall;
        always_comb begin
            rise = sync_i[i] & ~st_q.prev[i];
            fall = ~sync_i[i] & st_q.prev[i];
            if (mode_i[i]) begin
                cond[i] = pol_i[i] ? rise : fall;
            end else begin
                cond[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
            end
        end

        AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[i] && $past(mode_i[i]) && (pol_i[i] == $past(pol_i[i])) && $past(hit_o[i]))
            |-> !hit_o[i]); // R4
    end

    assign hit_o = cond & en_i;

endmodule

// File: rtl/eid_regs.sv
module eid_regs
    import eid_pkg::*;
#(
    parameter int unsigned      NUM_PINS  = 8,
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hAC
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [NUM_PINS-1:0] rdata_o,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] mode_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] flag_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] mode;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    reg_sel_e          sel;
    logic              flag_wr;

    always_comb begin
        offset   = addr_i - BASE_ADDR;
        in_range = (offset < ADDR_W'(NUM_REGS));
        sel      = reg_sel_e'(offset[1:0]);
        flag_wr  = wr_i && in_range && (sel == REG_FLAG);
    end

    always_comb begin
        st_d = st_q;
        if (wr_i && in_range) begin
            unique case (sel)
                REG_ENABLE: st_d.en   = wdata_i;
                REG_MODE:   st_d.mode = wdata_i;
                REG_POL:    st_d.pol  = wdata_i;
                REG_FLAG:   st_d.flag = st_q.flag & wdata_i;
                default:    st_d = st_q;
            endcase
        end
        st_d.flag = st_d.flag | hit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (in_range) begin
            unique case (sel)
                REG_ENABLE: rdata_o = st_q.en;
                REG_MODE:   rdata_o = st_q.mode;
                REG_POL:    rdata_o = st_q.pol;
                REG_FLAG:   rdata_o = st_q.flag;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;
    assign pol_o  = st_q.pol;
    assign flag_o = st_q.flag;

    AST_CLEAR_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_wr |=> ((st_q.flag & ~$past(wdata_i) & ~$past(hit_i)) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hit_i) |=> ((st_q.flag & $past(hit_i)) == $past(hit_i))); // R6
    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((st_q.flag & ~$past(st_q.flag) & ~$past(st_q.en)) == '0)); // R1
    AST_KEEP_WHEN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_wr |=> ((st_q.flag & $past(st_q.flag) & $past(wdata_i)) == ($past(st_q.flag) & $past(wdata_i)))); // R3

endmodule

// File: rtl/eid_top.sv
module eid_top #(
    parameter int unsigned       NUM_PINS  = 8,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hAC,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   sfr_addr_i,
    input  logic                sfr_wr_i,
    input  logic [NUM_PINS-1:0] sfr_wdata_i,
    output logic [NUM_PINS-1:0] sfr_rdata_o,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] en, mode, pol, flag;

    eid_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eid_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (pin_sync),
        .mode_i (mode),
        .pol_i  (pol),
        .en_i   (en),
        .hit_o  (hit)
    );

    eid_regs #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (sfr_addr_i),
        .wr_i    (sfr_wr_i),
        .wdata_i (sfr_wdata_i),
        .hit_i   (hit),
        .rdata_o (sfr_rdata_o),
        .en_o    (en),
        .mode_o  (mode),
        .pol_o   (pol),
        .flag_o  (flag)
    );

    assign irq_o     = flag;
    assign irq_any_o = |flag;

    AST_IRQ_TRACKS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_any_o == (irq_o != '0)); // R10

endmodule

// File: tb/tb_eid_top.sv
module tb_eid_top;

    localparam int unsigned N = 8;
    localparam logic [7:0] BASE = 8'hAC;
    localparam logic [7:0] A_EN = BASE + 8'd0;
    localparam logic [7:0] A_MODE = BASE + 8'd1;
    localparam logic [7:0] A_POL = BASE + 8'd2;
    localparam logic [7:0] A_FLAG = BASE + 8'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic [7:0] addr = '0;
    logic wr = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata, irq;
    logic irq_any;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    eid_top dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pin),
        .sfr_addr_i  (addr),
        .sfr_wr_i    (wr),
        .sfr_wdata_i (wdata),
        .sfr_rdata_o (rdata),
        .irq_o       (irq),
        .irq_any_o   (irq_any)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] v;
        logic exp_bit;
        idle(2);
        // R7 reset state
        rd_reg(A_EN, v);   check("R7 enable", v, '0);
        rd_reg(A_MODE, v); check("R7 mode", v, '0);
        rd_reg(A_POL, v);  check("R7 polarity", v, '0);
        rd_reg(A_FLAG, v); check("R7 flag", v, '0);
        check("R7 irq", irq, '0);
        rst_n = 1'b1;
        idle(2);

        // R9 register map and readback
        wr_reg(A_EN, 8'h00);
        wr_reg(A_MODE, 8'h5A); rd_reg(A_MODE, v); check("R9 mode readback", v, 8'h5A);
        wr_reg(A_POL, 8'hC3);  rd_reg(A_POL, v);  check("R9 pol readback", v, 8'hC3);
        wr_reg(A_EN, 8'h00);   rd_reg(A_EN, v);   check("R9 enable readback", v, 8'h00);
        wr_reg(BASE + 8'd4, 8'hFF);
        wr_reg(BASE - 8'd1, 8'hFF);
        rd_reg(BASE + 8'd4, v); check("R9 unmapped read", v, '0);
        rd_reg(A_MODE, v); check("R9 unmapped write ignored", v, 8'h5A);
        rd_reg(A_EN, v);   check("R9 unmapped write ignored en", v, 8'h00);

        // R1 R2 sweep: every pin, mode, polarity, enable, start/end level
        for (int p = 0; p < int'(N); p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int en = 0; en < 2; en++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int e = 0; e < 2; e++) begin
                            logic md, pl;
                            md = m[1]; pl = m[0];
                            wr_reg(A_EN, '0);
                            wr_reg(A_FLAG, '0);
                            wr_reg(A_MODE, md ? (N'(1) << p) : '0);
                            wr_reg(A_POL, pl ? (N'(1) << p) : '0);
                            @(negedge clk); pin = '0; pin[p] = s[0];
                            idle(5);
                            wr_reg(A_EN, en[0] ? (N'(1) << p) : '0);
                            wr_reg(A_FLAG, '0);
                            @(negedge clk); pin[p] = e[0];
                            idle(5);
                            if (md)
                                exp_bit = en[0] && (s != e) && (e[0] == pl);
                            else
                                exp_bit = en[0] && ((s[0] == pl) || (e[0] == pl));
                            rd_reg(A_FLAG, v);
                            check("R1 R2 sweep flag", v, exp_bit ? (N'(1) << p) : '0);
                            check("R10 sweep irq", {irq[N-1:1], irq[0]}, v);
                            check("R10 sweep any", {{(N-1){1'b0}}, irq_any}, {{(N-1){1'b0}}, |v});
                        end
                    end
                end
            end
        end

        // R8 latency, pin 0 rising edge
        wr_reg(A_EN, '0); @(negedge clk); pin = '0; idle(4);
        wr_reg(A_MODE, 8'h01); wr_reg(A_POL, 8'h01); wr_reg(A_EN, 8'h01); wr_reg(A_FLAG, '0);
        addr = A_FLAG;
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 after two edges", irq, 8'h00);
        @(negedge clk);
        check("R8 after three edges", irq, 8'h01);

        // R4 edge flag stays clear while level holds; R3 write-1 keeps
        wr_reg(A_FLAG, 8'hFF); idle(1);
        check("R3 write one keeps", irq, 8'h01);
        wr_reg(A_FLAG, 8'hFE); idle(4);
        check("R4 edge no reset", irq, 8'h00);

        // R3 selective clear: pins 1 and 2 rising, clear only pin 1
        wr_reg(A_MODE, 8'h06); wr_reg(A_POL, 8'h06); wr_reg(A_EN, 8'h06); wr_reg(A_FLAG, '0);
        @(negedge clk); pin[2:1] = 2'b11; idle(5);
        check("R3 both set", irq, 8'h06);
        wr_reg(A_FLAG, 8'hFD); idle(1);
        check("R3 selective clear", irq, 8'h04);

        // R5 R6 level-high on pin 3
        wr_reg(A_EN, '0); wr_reg(A_FLAG, '0);
        wr_reg(A_MODE, 8'h00); wr_reg(A_POL, 8'h08);
        @(negedge clk); pin[3] = 1'b1; idle(4);
        wr_reg(A_EN, 8'h08); idle(2);
        @(negedge clk); addr = A_FLAG; wdata = 8'h00; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check("R6 set beats clear", irq, 8'h08);
        idle(3);
        check("R5 level re-sets", irq, 8'h08);
        @(negedge clk); pin[3] = 1'b0; idle(4);
        wr_reg(A_FLAG, 8'h00); idle(2);
        check("R5 clear after inactive", irq, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule